// File: doc/BRIEF.md
# LIN Master Header Transmitter

This block drives the transmit line of a LIN node acting as bus master. A single-cycle break request, taken only in master mode with the transmitter enabled and idle, starts a frame header. The block holds the line dominant (low) for a programmable number of bit times, then releases it recessive (high) for a programmable delimiter. After the delimiter it sends the byte that software placed in the one-entry holding register as an ordinary 8N1 character. That byte is normally the sync value 0x55, written while the break is still on the line. All timing follows an external bit-rate tick that pulses once per bit time.

Outside a header the same path sends plain data characters, back to back when the holding register is refilled in time. The block reports an empty holding register, raises an interrupt request when that flag is set and interrupts are enabled, and emits a one-cycle pulse when the transmitter falls idle with nothing pending. Dropping the transmit enable aborts whatever is on the line.

The sequencer has six states:
- `ST_IDLE`: line high.
- `ST_BREAK`: line low.
- `ST_DELIM`: line high.
- `ST_START`: line low.
- `ST_DATA`: line carries shifter bit 0.
- `ST_STOP`: line high.

Its transitions are:
- Break accept: `ST_IDLE`→`ST_BREAK`.
- Idle launch on a tick with a byte pending: `ST_IDLE`→`ST_START`.
- Break done: `ST_BREAK`→`ST_DELIM`.
- Delimiter done: `ST_DELIM`→`ST_START` if a byte is held, else `ST_DELIM`→`ST_IDLE`.
- Start done: `ST_START`→`ST_DATA`.
- Last data bit: `ST_DATA`→`ST_STOP`.
- Stop done: `ST_STOP`→`ST_START` if a byte is held, else `ST_STOP`→`ST_IDLE`.
- Abort: any state→`ST_IDLE` while the enable is low.

Top module: `lin_hdr_tx`

## Requirements
- R1: An accepted break request drives `tx_line` low for 13 + `brk_code` bit ticks, so codes 0, 1, 2 and 3 give 13, 14, 15 and 16 ticks.
- R2: The break is followed by `tx_line` high for 1 + `dlm_code` bit ticks, so codes 0 to 3 give 1 to 4 ticks.
- R3: A byte written during the break or delimiter is sent starting at the tick that ends the delimiter. It goes out as one low start bit, eight data bits LSB first, and one high stop bit, each lasting one tick.
- R4: A break request is ignored, and `tx_line` stays high, when `slave_sel` is 1 (slave mode), when `tx_en` is 0, or when the sequencer is not idle.
- R5: While `tx_en` is 0 the sequencer is forced idle, `tx_line` is high from the next clock, the holding register is emptied, and writes are ignored.
- R6: `tdre` is 1 exactly when the holding register is empty. A write while it is full is ignored, and the held byte is kept.
- R7: `irq` equals `irq_en` AND `tdre`.
- R8: `bus_idle` pulses for one clock when the sequencer returns to idle with an empty holding register and `tx_en` high, and never stays high two clocks running.
- R9: In idle, a written byte starts its start bit at the next tick. A byte written while a character is on the line starts right after that character's stop bit, with no idle gap.
- R10: After reset `tx_line` is 1, `tdre` is 1, and `irq` and `bus_idle` are 0 with `irq_en` and `tx_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| slave_sel | input | 1 | 0 selects master mode, 1 selects slave mode |
| tx_en | input | 1 | Transmit enable; low aborts and flushes |
| brk_req | input | 1 | Single-cycle break request |
| brk_code | input | 2 | Break length code (13 + code ticks) |
| dlm_code | input | 2 | Delimiter length code (1 + code ticks) |
| wr_en | input | 1 | Holding register write strobe |
| wr_data | input | DATA_BITS | Byte to transmit |
| irq_en | input | 1 | Transmit interrupt enable |
| tx_line | output | 1 | Serial transmit line, idle high |
| tdre | output | 1 | Holding register empty |
| irq | output | 1 | Transmit interrupt request |
| bus_idle | output | 1 | One-cycle idle indication |

## Verification
The bench builds the block with its default bases: a break base of 13, a delimiter base of 1 and 8 data bits. A bit tick arrives every fourth clock, so the longest header plus one character fits in a few hundred clocks. The header tests cover the shortest and longest break and delimiter codes, plus one mixed pair. Further tests cover back-to-back characters, an overwrite attempt, requests in slave mode and with the enable low, and an abort in the middle of a break.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BREAK,
        ST_DELIM,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lin_hold_buf.sv
module lin_hold_buf #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 load,
    output logic                 full,
    output logic [DATA_BITS-1:0] data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (!tx_en) begin
            full <= 1'b0;
        end else if (load) begin
            full <= 1'b0;
        end else if (wr_en && !full) begin
            full <= 1'b1;
            data <= wr_data;
        end
    end

    AST_HELD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !load && tx_en) |=> (full && $stable(data))); // R6

    AST_LOAD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> full); // R3

endmodule

// File: rtl/lin_hdr_seq.sv
module lin_hdr_seq
    import lin_hdr_pkg::*;
#(
    parameter int BRK_BASE  = 13,
    parameter int DLM_BASE  = 1,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 tx_en,
    input  logic                 slave_sel,
    input  logic                 brk_req,
    input  logic [1:0]           brk_code,
    input  logic [1:0]           dlm_code,
    input  logic                 hold_full,
    input  logic [DATA_BITS-1:0] hold_data,
    output logic                 load,
    output logic                 tx,
    output logic                 idle
);

    localparam int MAX_CNT = max3(BRK_BASE + 3, DLM_BASE + 3, DATA_BITS);
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    tx_state_t            state, state_n;
    logic [CNT_W-1:0]     cnt, cnt_n;
    logic [CNT_W-1:0]     brk_len, brk_len_n;
    logic [CNT_W-1:0]     dlm_len, dlm_len_n;
    logic [DATA_BITS-1:0] shreg, shreg_n;

    // next-state logic
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        brk_len_n = brk_len;
        dlm_len_n = dlm_len;
        shreg_n   = shreg;
        load      = 1'b0;
        if (!tx_en) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (brk_req && !slave_sel) begin
                        state_n   = ST_BREAK;
                        cnt_n     = '0;
                        brk_len_n = CNT_W'(BRK_BASE) + CNT_W'(brk_code);
                        dlm_len_n = CNT_W'(DLM_BASE) + CNT_W'(dlm_code);
                    end else if (bit_tick && hold_full) begin
                        state_n = ST_START;
                        shreg_n = hold_data;
                        load    = 1'b1;
                    end
                end
                ST_BREAK: begin
                    if (bit_tick) begin
                        if (cnt == brk_len - CNT_W'(1)) begin
                            state_n = ST_DELIM;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end
                end
                ST_DELIM: begin
                    if (bit_tick) begin
                        if (cnt == dlm_len - CNT_W'(1)) begin
                            cnt_n = '0;
                            if (hold_full) begin
                                state_n = ST_START;
                                shreg_n = hold_data;
                                load    = 1'b1;
                            end else begin
                                state_n = ST_IDLE;
                            end
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end
                end
                ST_START: begin
                    if (bit_tick) begin
                        state_n = ST_DATA;
                        cnt_n   = '0;
                    end
                end
                ST_DATA: begin
                    if (bit_tick) begin
                        shreg_n = shreg >> 1;
                        if (cnt == CNT_W'(DATA_BITS - 1)) begin
                            state_n = ST_STOP;
                            cnt_n   = '0;
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (bit_tick) begin
                        if (hold_full) begin
                            state_n = ST_START;
                            shreg_n = hold_data;
                            load    = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            brk_len <= CNT_W'(BRK_BASE);
            dlm_len <= CNT_W'(DLM_BASE);
            shreg   <= '0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            brk_len <= brk_len_n;
            dlm_len <= dlm_len_n;
            shreg   <= shreg_n;
        end
    end

    // outputs
    always_comb begin
        idle = (state == ST_IDLE);
        unique case (state)
            ST_BREAK: tx = 1'b0;
            ST_START: tx = 1'b0;
            ST_DATA:  tx = shreg[0];
            default:  tx = 1'b1;
        endcase
    end

    AST_BREAK_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_BREAK) |-> $past(brk_req && !slave_sel && tx_en)); // R4

    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (state == ST_IDLE)); // R5

    AST_BREAK_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BREAK) |-> (cnt < brk_len)); // R1

    AST_DELIM_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELIM) |-> (cnt < dlm_len)); // R2

    AST_DATA_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_START && state != ST_START && tx_en) |-> (state == ST_DATA)); // R3

endmodule

// File: rtl/lin_hdr_tx.sv
module lin_hdr_tx #(
    parameter int BRK_BASE  = 13,
    parameter int DLM_BASE  = 1,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_tick,
    input  logic                 slave_sel,
    input  logic                 tx_en,
    input  logic                 brk_req,
    input  logic [1:0]           brk_code,
    input  logic [1:0]           dlm_code,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 irq_en,
    output logic                 tx_line,
    output logic                 tdre,
    output logic                 irq,
    output logic                 bus_idle
);

    logic                 hold_full;
    logic [DATA_BITS-1:0] hold_data;
    logic                 load;
    logic                 seq_idle;
    logic                 quiet_now;
    logic                 quiet_q;

    lin_hold_buf #(
        .DATA_BITS (DATA_BITS)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .load    (load),
        .full    (hold_full),
        .data    (hold_data)
    );

    lin_hdr_seq #(
        .BRK_BASE  (BRK_BASE),
        .DLM_BASE  (DLM_BASE),
        .DATA_BITS (DATA_BITS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .slave_sel (slave_sel),
        .brk_req   (brk_req),
        .brk_code  (brk_code),
        .dlm_code  (dlm_code),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .load      (load),
        .tx        (tx_line),
        .idle      (seq_idle)
    );

    assign quiet_now = seq_idle && !hold_full && tx_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) quiet_q <= 1'b1;
        else        quiet_q <= quiet_now;
    end

    assign tdre     = !hold_full;
    assign irq      = irq_en && tdre;
    assign bus_idle = quiet_now && !quiet_q;

    AST_IRQ_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (tdre && irq_en)); // R7

    AST_IDLE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_idle |=> !bus_idle); // R8

    AST_DISABLED_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> tx_line); // R5

endmodule

// File: tb/lin_hdr_tx_bench.sv
`timescale 1ns/1ps
module lin_hdr_tx_bench;

    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       slave_sel = 1'b0;
    logic       tx_en = 1'b0;
    logic       brk_req = 1'b0;
    logic [1:0] brk_code = 2'd0;
    logic [1:0] dlm_code = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       irq_en = 1'b0;
    logic       tx_line, tdre, irq, bus_idle;

    int    n_checks = 0;
    int    n_fails = 0;
    int    idle_pulses = 0;
    int    div_cnt = 0;
    bit    mon_active = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";
    bit    exp_q[$];

    always #4 clk = ~clk;

    lin_hdr_tx u_lin_hdr_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .slave_sel (slave_sel),
        .tx_en     (tx_en),
        .brk_req   (brk_req),
        .brk_code  (brk_code),
        .dlm_code  (dlm_code),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .irq_en    (irq_en),
        .tx_line   (tx_line),
        .tdre      (tdre),
        .irq       (irq),
        .bus_idle  (bus_idle)
    );

    always @(posedge clk) begin
        div_cnt  <= (div_cnt == DIV - 1) ? 0 : div_cnt + 1;
        bit_tick <= (div_cnt == DIV - 2);
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: one line sample per bit tick
    always @(negedge clk) begin
        if (mon_active && bit_tick && exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            check(cur_req, int'(tx_line), int'(e));
        end
        if (bus_idle) idle_pulses++;
    end

    task automatic push_bits(input bit v, input int n);
        for (int i = 0; i < n; i++) exp_q.push_back(v);
    endtask

    task automatic push_char(input logic [7:0] b);
        exp_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
        exp_q.push_back(1'b1);
    endtask

    task automatic wait_safe();
        @(negedge clk);
        while (!bit_tick) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        mon_active = 1'b0;
        repeat (3 * DIV) @(negedge clk);
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic start_header(input logic [1:0] b, input logic [1:0] d);
        wait_safe();
        brk_code = b; dlm_code = d;
        brk_req = 1'b1; mon_active = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
    endtask

    task automatic header(input logic [1:0] b, input logic [1:0] d, input logic [7:0] v);
        push_bits(1'b0, 13 + int'(b));
        push_bits(1'b1, 1 + int'(d));
        push_char(v);
        start_header(b, d);
        write_byte(v);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10 reset state
        check("R10", int'(tx_line), 1);
        check("R10", int'(tdre), 1);
        check("R10", int'(irq), 0);
        check("R10", int'(bus_idle), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        tx_en = 1'b1;
        repeat (4 * DIV) @(negedge clk);

        // R1 R2 R3 shortest header, R8 idle pulse count
        idle_pulses = 0;
        cur_req = "R1_R2_R3";
        header(2'd0, 2'd0, 8'h55);
        check("R8", idle_pulses, 1);

        // R1 R2 R3 longest codes
        cur_req = "R1_R2_R3";
        header(2'd3, 2'd3, 8'hA3);

        // R9 back-to-back characters after a header
        cur_req = "R9";
        push_bits(1'b0, 14);
        push_bits(1'b1, 3);
        push_char(8'h55);
        push_char(8'h0F);
        start_header(2'd1, 2'd2);
        write_byte(8'h55);
        check("R6", int'(tdre), 0);
        while (!tdre) @(negedge clk);
        write_byte(8'h0F);
        drain();

        // R9 character launched from idle
        cur_req = "R9";
        wait_safe();
        push_bits(1'b1, 1);
        push_char(8'hC6);
        mon_active = 1'b1;
        write_byte(8'hC6);
        drain();

        // R4 slave mode ignores break
        cur_req = "R4";
        slave_sel = 1'b1;
        push_bits(1'b1, 6);
        start_header(2'd0, 2'd0);
        drain();
        check("R4", int'(tdre), 1);
        slave_sel = 1'b0;

        // R4 disabled transmitter ignores break
        tx_en = 1'b0;
        push_bits(1'b1, 5);
        start_header(2'd2, 2'd0);
        drain();
        tx_en = 1'b1;
        repeat (2 * DIV) @(negedge clk);

        // R6 R7 write while full ignored, interrupt follows empty flag
        irq_en = 1'b1;
        @(negedge clk);
        check("R7", int'(irq), 1);
        cur_req = "R6";
        push_bits(1'b0, 13);
        push_bits(1'b1, 1);
        push_char(8'h3C);
        push_bits(1'b1, 2);
        start_header(2'd0, 2'd0);
        write_byte(8'h3C);
        check("R6", int'(tdre), 0);
        check("R7", int'(irq), 0);
        write_byte(8'hFF);
        check("R6", int'(tdre), 0);
        drain();
        check("R7", int'(irq), 1);
        irq_en = 1'b0;
        @(negedge clk);
        check("R7", int'(irq), 0);

        // R5 abort in the middle of a break
        start_header(2'd2, 2'd0);
        mon_active = 1'b0;
        write_byte(8'h5A);
        repeat (3 * DIV) @(negedge clk);
        check("R1", int'(tx_line), 0);
        tx_en = 1'b0;
        @(negedge clk);
        check("R5", int'(tx_line), 1);
        check("R5", int'(tdre), 1);
        write_byte(8'h11);
        check("R5", int'(tdre), 1);
        tx_en = 1'b1;
        repeat (4 * DIV) @(negedge clk);
        check("R5", int'(tx_line), 1);
        check("R5", int'(tdre), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule